// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the device-side front end of a byte-wide electrically erasable array. A host drives active-low chip-select, output-enable and write-strobe lines together with an address and a data byte. Bytes written while a programming-enable input is high are treated as commands. Commands select what reads return: the array, the identifier codes, or a margin-verify view of one byte. They also arm and start the two destructive operations, a whole-array erase and a single-byte program. Every input is sampled on the rising edge of `clk`. The tri-state data bus is modelled as a data output `dout` plus a drive qualifier `dout_oe`.

Destructive work needs two writes: an arming command, then an execute write. Two consecutive FFH writes after an arming command cancel it. Each operation runs for a fixed number of clocks, counted by an internal stop timer. When the timer runs out, the operation's effect is committed and the block parks. It stays parked until the matching verify command or a reset command arrives.

Erase sets every byte to FFH, sweeping one byte per clock. Programming writes the AND of the stored byte and the new data. The array is a simple one-write, one-read memory with a registered read port.

Top module: `nvm_cmd_if`

## Requirements
- R1: After `rst`, `dout_oe` and `dout` are 0 and the block is in array-read mode. Array contents survive reset, and a reset taken in identifier mode brings reads back to array data.
- R2: `dout_oe` is 1 two clocks after a cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1, and 0 two clocks after any other cycle; `dout` is 00H whenever `dout_oe` is 0.
- R3: A write is a low pulse with both `ce_n` and `we_n` low. The address is taken in the first clock of the pulse and the data in the clock where the pulse ends. The command acts within three clocks of that end.
- R4: In array-read mode (command 00H, also entered by FFH), reads return the stored byte at `addr`. In the arming, running, parked and abort-pending states, enabled reads return 00H.
- R5: After command 90H, reads at address 0 return 89H, at address 1 return B4H, and at any other address 00H.
- R6: 40H followed by a write of address A and data D starts a program. When the program finishes, byte A holds its old value AND D. Command C0H then makes every read return byte A, whatever `addr` is.
- R7: 20H followed by 20H starts an erase that sets all bytes to FFH within ERASE_CYCLES clocks (ERASE_CYCLES > 2^ADDR_W). Command A0H written with address V makes every read return byte V.
- R8: When the stop timer expires (PROG_CYCLES or ERASE_CYCLES clocks), the block parks. Reads return 00H, and every write except the matching verify (C0H for program, A0H for erase) or FFH is ignored.
- R9: A program ended by C0H before its timer expires leaves the byte unchanged, and no change happens later.
- R10: After either arming command, FFH followed by any write returns to array-read mode with the array unchanged.
- R11: After 20H, a write of any byte other than 20H or FFH returns to array-read mode without erasing.
- R12: While `prog_en` is 0 the block is held in array-read mode and all writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_en | input | 1 | High allows commands; low forces read-only |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data, 00H when not driven |
| dout_oe | output | 1 | High when the data bus would be driven |

## Verification
Every write moves the address bus and the data bus during the strobe, so a design that latches at the wrong end of the pulse lands the byte in the wrong place. The same address is programmed twice with bit patterns that overlap in part. Random address and data programs on an erased array then separate an AND-merge from a plain overwrite. A verify issued before the timer runs out, and reads taken while parked, show whether the effect is committed only at expiry and whether the parked state rejects unrelated commands. The abort paths, the erase-arm escape and the disabled `prog_en` are each followed by a read of a byte known to be non-erased, which shows that no erase or program slipped through.

// File: rtl/nvm_cmd_pkg.sv
`timescale 1ns/1ps
package nvm_cmd_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CMD_READ    = 8'h00;
  localparam byte_t CMD_IDENT   = 8'h90;
  localparam byte_t CMD_ERASE   = 8'h20;
  localparam byte_t CMD_ERS_VFY = 8'hA0;
  localparam byte_t CMD_PROG    = 8'h40;
  localparam byte_t CMD_PRG_VFY = 8'hC0;
  localparam byte_t CMD_RESET   = 8'hFF;

  localparam byte_t ID_MAKER  = 8'h89;
  localparam byte_t ID_DEVICE = 8'hB4;

  typedef enum logic [3:0] {
    MD_READ, MD_IDENT,
    MD_ERS_ARM, MD_ERS_RUN, MD_ERS_PARK, MD_ERS_CHK,
    MD_PRG_ARM, MD_PRG_RUN, MD_PRG_PARK, MD_PRG_CHK,
    MD_ABORT
  } mode_e;

  typedef enum logic [1:0] { RS_ZERO, RS_ARRAY, RS_ID } rsrc_e;

  // What an enabled read returns in each mode
  function automatic rsrc_e mode_src(mode_e m);
    case (m)
      MD_READ, MD_ERS_CHK, MD_PRG_CHK: return RS_ARRAY;
      MD_IDENT:                        return RS_ID;
      default:                         return RS_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/nvm_strobe_sync.sv
`timescale 1ns/1ps
// Finds the edges of the combined select/strobe pulse: address at its start, data at its end.
module nvm_strobe_sync
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             din,
  output logic              cmd_vld,
  output logic [ADDR_W-1:0] cmd_addr,
  output byte_t             cmd_data
);
  logic wr_act, act_q;

  assign wr_act = !ce_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      cmd_vld  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      act_q   <= wr_act;
      cmd_vld <= act_q && !wr_act;
      if (wr_act && !act_q) cmd_addr <= addr;
      if (act_q && !wr_act) cmd_data <= din;
    end
  end
endmodule

// File: rtl/nvm_byte_array.sv
`timescale 1ns/1ps
// One write port, one registered read port, no reset: maps onto block RAM.
module nvm_byte_array
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  byte_t             wdata,
  input  logic [ADDR_W-1:0] raddr,
  output byte_t             rdata
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvm_cmd_fsm.sv
`timescale 1ns/1ps
// Command decoder, stop timer, erase sweep and program read-modify-write.
module nvm_cmd_fsm
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int PROG_CYCLES  = 24,
  parameter int ERASE_CYCLES = 96,
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int TW      = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_en,
  input  logic              cmd_vld,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  byte_t             cmd_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  byte_t             rdata,
  output mode_e             mode,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output byte_t             mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr
);
  mode_e             mode_q;
  logic [TW-1:0]     tmr_q;
  logic [ADDR_W:0]   sweep_q;
  logic [ADDR_W-1:0] pa_q, va_q;
  byte_t             pd_q;
  logic              expire, running, sweeping;

  assign expire   = (tmr_q == '0);
  assign running  = (mode_q == MD_ERS_RUN) || (mode_q == MD_PRG_RUN);
  assign sweeping = (mode_q == MD_ERS_RUN) && !sweep_q[ADDR_W];
  assign mode     = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_READ;
      tmr_q   <= '0;
      sweep_q <= '0;
      pa_q    <= '0;
      va_q    <= '0;
      pd_q    <= '0;
    end else if (!prog_en) begin
      mode_q <= MD_READ;
    end else begin
      if (running && !expire) tmr_q <= tmr_q - TW'(1);
      if (sweeping) sweep_q <= sweep_q + (ADDR_W+1)'(1);
      if (expire && mode_q == MD_ERS_RUN) mode_q <= MD_ERS_PARK;
      if (expire && mode_q == MD_PRG_RUN) mode_q <= MD_PRG_PARK;
      if (cmd_vld) begin
        case (mode_q)
          MD_READ, MD_IDENT, MD_ERS_CHK, MD_PRG_CHK: begin
            case (cmd_data)
              CMD_READ, CMD_RESET: mode_q <= MD_READ;
              CMD_IDENT:           mode_q <= MD_IDENT;
              CMD_ERASE:           mode_q <= MD_ERS_ARM;
              CMD_PROG:            mode_q <= MD_PRG_ARM;
              CMD_ERS_VFY: begin
                mode_q <= MD_ERS_CHK;
                va_q   <= cmd_addr;
              end
              CMD_PRG_VFY:         mode_q <= MD_PRG_CHK;
              default: ;
            endcase
          end
          MD_ERS_ARM: begin
            if (cmd_data == CMD_ERASE) begin
              mode_q  <= MD_ERS_RUN;
              tmr_q   <= TW'(ERASE_CYCLES - 1);
              sweep_q <= '0;
            end else if (cmd_data == CMD_RESET) begin
              mode_q <= MD_ABORT;
            end else begin
              mode_q <= MD_READ;
            end
          end
          MD_PRG_ARM: begin
            if (cmd_data == CMD_RESET) begin
              mode_q <= MD_ABORT;
            end else begin
              mode_q <= MD_PRG_RUN;
              pa_q   <= cmd_addr;
              pd_q   <= cmd_data;
              tmr_q  <= TW'(PROG_CYCLES - 1);
            end
          end
          MD_ERS_RUN, MD_ERS_PARK: begin
            if (cmd_data == CMD_ERS_VFY) begin
              mode_q <= MD_ERS_CHK;
              va_q   <= cmd_addr;
            end else if (cmd_data == CMD_RESET) begin
              mode_q <= MD_ABORT;
            end
          end
          MD_PRG_RUN, MD_PRG_PARK: begin
            if (cmd_data == CMD_PRG_VFY)    mode_q <= MD_PRG_CHK;
            else if (cmd_data == CMD_RESET) mode_q <= MD_ABORT;
          end
          default: mode_q <= MD_READ;
        endcase
      end
    end
  end

  // Erase writes FFH one byte per clock; program commits old AND new at timer expiry.
  always_comb begin
    mem_we    = prog_en && (sweeping || (mode_q == MD_PRG_RUN && expire));
    mem_waddr = sweeping ? sweep_q[ADDR_W-1:0] : pa_q;
    mem_wdata = sweeping ? '1 : (rdata & pd_q);
    case (mode_q)
      MD_PRG_RUN, MD_PRG_PARK, MD_PRG_CHK: mem_raddr = pa_q;
      MD_ERS_CHK:                          mem_raddr = va_q;
      default:                             mem_raddr = bus_addr;
    endcase
  end
endmodule

// File: rtl/nvm_read_port.sv
`timescale 1ns/1ps
// Two-stage read path: stage 1 aligns with the array read, stage 2 drives the pins.
module nvm_read_port
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  mode_e             mode,
  input  byte_t             rdata,
  output byte_t             dout,
  output logic              dout_oe
);
  logic  en1;
  rsrc_e src1;
  byte_t id1, id_sel;

  always_comb begin
    if (addr == ADDR_W'(0))      id_sel = ID_MAKER;
    else if (addr == ADDR_W'(1)) id_sel = ID_DEVICE;
    else                         id_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en1     <= 1'b0;
      src1    <= RS_ZERO;
      id1     <= '0;
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      en1     <= !ce_n && !oe_n && we_n;
      src1    <= mode_src(mode);
      id1     <= id_sel;
      dout_oe <= en1;
      if (!en1)                  dout <= '0;
      else if (src1 == RS_ARRAY) dout <= rdata;
      else if (src1 == RS_ID)    dout <= id1;
      else                       dout <= '0;
    end
  end
endmodule

// File: rtl/nvm_cmd_if.sv
`timescale 1ns/1ps
module nvm_cmd_if
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int PROG_CYCLES  = 24,
  parameter int ERASE_CYCLES = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_en,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  logic              cmd_vld_w;
  logic [ADDR_W-1:0] cmd_addr_w;
  byte_t             cmd_data_w;
  mode_e             mode_w;
  logic              mem_we_w;
  logic [ADDR_W-1:0] mem_waddr_w, mem_raddr_w;
  byte_t             mem_wdata_w, mem_rdata_w;

  nvm_strobe_sync #(.ADDR_W(ADDR_W)) strobe_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .cmd_vld(cmd_vld_w), .cmd_addr(cmd_addr_w), .cmd_data(cmd_data_w)
  );

  nvm_cmd_fsm #(
    .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) fsm_i (
    .clk(clk), .rst(rst), .prog_en(prog_en),
    .cmd_vld(cmd_vld_w), .cmd_addr(cmd_addr_w), .cmd_data(cmd_data_w),
    .bus_addr(addr), .rdata(mem_rdata_w), .mode(mode_w),
    .mem_we(mem_we_w), .mem_waddr(mem_waddr_w), .mem_wdata(mem_wdata_w),
    .mem_raddr(mem_raddr_w)
  );

  nvm_byte_array #(.ADDR_W(ADDR_W)) array_i (
    .clk(clk), .we(mem_we_w), .waddr(mem_waddr_w), .wdata(mem_wdata_w),
    .raddr(mem_raddr_w), .rdata(mem_rdata_w)
  );

  nvm_read_port #(.ADDR_W(ADDR_W)) rport_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .mode(mode_w), .rdata(mem_rdata_w), .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/nvm_cmd_if_chk.sv
`timescale 1ns/1ps
module nvm_cmd_if_chk
  import nvm_cmd_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  prog_en,
  input logic  ce_n,
  input logic  oe_n,
  input logic  we_n,
  input logic  dout_oe,
  input logic  cmd_vld,
  input mode_e mode
);
  AST_DRIVE_ON: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n) |=> ##1 dout_oe); // R2
  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !we_n) |=> ##1 !dout_oe); // R2
  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (rst)
    !prog_en |=> (mode == MD_READ)); // R12
  AST_ERASE_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_ERS_RUN && $past(mode) != MD_ERS_RUN) |-> ($past(mode) == MD_ERS_ARM)); // R7
  AST_PROG_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PRG_RUN && $past(mode) != MD_PRG_RUN) |-> ($past(mode) == MD_PRG_ARM)); // R6
  AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PRG_PARK && !cmd_vld && prog_en) |=> (mode == MD_PRG_PARK)); // R8
  AST_ABORT_EXITS: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_ABORT && cmd_vld) |=> (mode == MD_READ)); // R10
endmodule

bind nvm_cmd_if nvm_cmd_if_chk chk_i (
  .clk(clk), .rst(rst), .prog_en(prog_en), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout_oe(dout_oe), .cmd_vld(cmd_vld_w), .mode(mode_w)
);

// File: tb/nvm_cmd_if_tb_top.sv
`timescale 1ns/1ps
module nvm_cmd_if_tb_top;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int PROG_CYCLES = 24;
  localparam int ERASE_CYCLES = 96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_en = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe;

  int checks = 0;
  int fails = 0;
  logic [7:0] mdl [DEPTH];

  always #2.5 clk = ~clk;

  nvm_cmd_if #(.ADDR_W(AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) dut_i (
    .clk(clk), .rst(rst), .prog_en(prog_en), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  // Bus write: address and data buses change mid-pulse (R3).
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = ~d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = ~a; din = d;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic oe, input logic ce,
                    output logic [7:0] v, output logic en);
    @(negedge clk); addr = a; ce_n = ce; oe_n = oe;
    repeat (3) @(negedge clk);
    v = dout; en = dout_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] v; logic en;
    rd(a, 1'b0, 1'b0, v, en);
    checks++;
    if (en !== 1'b1 || v !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d act=%02h oe=%b exp=%02h oe=1", req, a, v, en, exp);
    end
  endtask

  task automatic offchk(input string req, input logic oe, input logic ce);
    logic [7:0] v; logic en;
    rd(6'd12, oe, ce, v, en);
    checks++;
    if (en !== 1'b0 || v !== 8'h00) begin
      fails++;
      $display("FAIL %s act=%02h oe=%b exp=00 oe=0", req, v, en);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] prog_result(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(6'd0, 8'h40);
    wr(a, d);
    wait_cyc(PROG_CYCLES + 4);
    wr(6'd0, 8'hC0);
    mdl[a] = prog_result(mdl[a], d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (dout_oe !== 1'b0 || dout !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset outputs act=%02h oe=%b exp=00 oe=0", dout, dout_oe);
    end

    // R7: full erase then erase verify at a latched address
    wr(6'd0, 8'h20);
    wr(6'd0, 8'h20);
    wait_cyc(ERASE_CYCLES + 4);
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
    wr(6'd9, 8'hA0);
    rdchk("R7 erase verify", 6'd3, 8'hFF);
    wr(6'd0, 8'h00);
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      rdchk("R7 erased byte", a, 8'hFF);
    end

    // R5: identifier codes
    wr(6'd0, 8'h90);
    rdchk("R5 maker code", 6'd0, 8'h89);
    rdchk("R5 device code", 6'd1, 8'hB4);
    rdchk("R5 other address", 6'd5, 8'h00);
    wr(6'd0, 8'h00);

    // R6 / R3: program, verify at any bus address, AND merge
    do_prog(6'd12, 8'h5A);
    rdchk("R3 latched address/data via verify", 6'd3, 8'h5A);
    wr(6'd0, 8'h00);
    rdchk("R4 array read", 6'd12, 8'h5A);
    do_prog(6'd12, 8'h0F);
    rdchk("R6 AND merge", 6'd40, 8'h0A);
    wr(6'd0, 8'h00);

    // R8: parked after timer, ignores other commands until C0H
    wr(6'd0, 8'h40);
    wr(6'd20, 8'h33);
    wait_cyc(PROG_CYCLES + 4);
    rdchk("R8 parked read", 6'd20, 8'h00);
    wr(6'd0, 8'h90);
    rdchk("R8 parked ignores 90H", 6'd0, 8'h00);
    wr(6'd0, 8'hC0);
    mdl[20] = prog_result(mdl[20], 8'h33);
    rdchk("R8 verify after park", 6'd7, mdl[20]);
    wr(6'd0, 8'h00);

    // R9: verify before expiry leaves the byte unchanged
    wr(6'd0, 8'h40);
    wr(6'd30, 8'h11);
    wr(6'd0, 8'hC0);
    rdchk("R9 early verify", 6'd1, 8'hFF);
    wait_cyc(PROG_CYCLES + 4);
    rdchk("R9 no late commit", 6'd1, 8'hFF);
    wr(6'd0, 8'h00);
    rdchk("R9 array after early end", 6'd30, mdl[30]);

    // R10: FFH FFH aborts both arming commands
    wr(6'd0, 8'h40);
    wr(6'd0, 8'hFF);
    wr(6'd0, 8'hFF);
    rdchk("R10 program abort", 6'd12, mdl[12]);
    wr(6'd0, 8'h20);
    wr(6'd0, 8'hFF);
    wr(6'd0, 8'hFF);
    wait_cyc(ERASE_CYCLES + 4);
    rdchk("R10 erase abort", 6'd20, mdl[20]);

    // R11: other byte after erase arm returns to read
    wr(6'd0, 8'h20);
    wr(6'd0, 8'h55);
    rdchk("R11 read mode after stray byte", 6'd12, mdl[12]);
    wait_cyc(ERASE_CYCLES + 4);
    rdchk("R11 no erase", 6'd20, mdl[20]);

    // R12: writes ignored while prog_en is low
    @(negedge clk); prog_en = 1'b0;
    wr(6'd0, 8'h90);
    rdchk("R12 identifier blocked", 6'd0, mdl[0]);
    wr(6'd0, 8'h40);
    wr(6'd12, 8'h00);
    wait_cyc(PROG_CYCLES + 4);
    rdchk("R12 program blocked", 6'd12, mdl[12]);
    @(negedge clk); prog_en = 1'b1;

    // R2: output drive qualifiers
    offchk("R2 oe_n high", 1'b1, 1'b0);
    offchk("R2 ce_n high", 1'b0, 1'b1);

    // R1: reset from identifier mode returns to array read, contents kept
    wr(6'd0, 8'h90);
    @(negedge clk); rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    rdchk("R1 read mode after reset", 6'd0, mdl[0]);
    rdchk("R1 contents kept", 6'd12, mdl[12]);

    // Random programs checked against the model (R6, R4)
    for (int n = 0; n < 12; n++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [7:0] d = 8'($urandom);
      do_prog(a, d);
      rdchk("R6 random program verify", a, mdl[a]);
    end
    wr(6'd0, 8'h00);
    for (int i = 0; i < DEPTH; i++) rdchk("R4 final array sweep", AW'(i), mdl[i]);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule